// File: doc/BRIEF.md
# Pipelined Word Memory Slave

This block is a synchronous, word-addressed RAM that sits on a pipelined Wishbone bus as a slave. It has a 32-bit data path and four byte-select lines. It never stalls, so a bus master can issue one request on every clock. Each accepted request, read or write, is answered one clock later with an acknowledge and the addressed word.

The number of words is a parameter. The block rounds it up to the next power of two, and any address beyond that range wraps onto the stored words. Writes merge the selected bytes into the stored word. The word returned for a write is the merged result. When no request was taken, the data output repeats the write-data input from the clock before.

Top module: `wb_word_ram`

## Requirements
- R1: The storage holds 2^ceil(log2(WORDS)) words. Only the low ceil(log2(WORDS)) address bits select a word, so an address at or beyond that depth reaches the same word as the address minus the depth.
- R2: Select bit 0 enables data bits 7:0, bit 1 enables 15:8, bit 2 enables 23:16 and bit 3 enables 31:24.
- R3: A write with all four select bits high replaces the whole word. A write with fewer select bits changes only the enabled bytes, and every other byte keeps its stored value.
- R4: A request is taken in every clock in which cyc_i and stb_i are both high. stall_o is always low, so back-to-back requests are each served.
- R5: ack_o is high in the clock after a taken request, and only while cyc_i is high in that clock. A request whose cycle is dropped before then gets no acknowledge.
- R6: The word on dat_o in the clock after a taken request is the addressed word after that request's own write. For a read this is the stored word, whatever the select value.
- R7: In the clock after a clock with no taken request, dat_o equals the dat_i value from that earlier clock.
- R8: rst is synchronous and active high. A request presented while rst is high is not taken: it produces no acknowledge and writes nothing. Reset does not clear memory contents.
- R9: Every word reads as zero until it is first written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | High for a write, low for a read |
| adr_i | input | AW | Word address |
| dat_i | input | 32 | Write data |
| sel_i | input | 4 | Byte lane enables |
| ack_o | output | 1 | Response valid |
| stall_o | output | 1 | Always low |
| dat_o | output | 32 | Response data, or the echoed write data when idle |

## Verification
Two events can fall in the same clock. The response to the previous request can be due in the same clock as a new request, and the cycle can be dropped in the same clock as a response falls due. The bench provokes the first case with unbroken runs of mixed reads and writes to the same and to wrapping addresses. It provokes the second by lowering cyc_i right after a request. A scoreboard of expected items, one per clock, judges every clock: it computes the acknowledge from the bench's own cyc_i in that clock and the data from a reference array of merged words.

// File: rtl/wb_word_ram.sv
module wb_word_ram #(
  parameter int WORDS = 1000,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [31:0]   dat_i,
  input  logic [3:0]    sel_i,
  output logic          ack_o,
  output logic          stall_o,
  output logic [31:0]   dat_o
);

  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int DEPTH = 1 << IW;

  logic [31:0]   mem [DEPTH];
  logic [IW-1:0] idx;
  logic [31:0]   lane_mask, cur, merged, out_q;
  logic          take, pend_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign idx  = adr_i[IW-1:0];
  assign take = cyc_i && stb_i && !rst;
  assign cur  = mem[idx];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_mask[8*g +: 8] = {8{sel_i[g]}};
  end

  assign merged  = we_i ? ((cur & ~lane_mask) | (dat_i & lane_mask)) : cur;
  assign ack_o   = pend_q && cyc_i;
  assign stall_o = 1'b0;
  assign dat_o   = out_q;

  always_ff @(posedge clk) begin
    if (take && we_i) mem[idx] <= merged;
  end

  always_ff @(posedge clk) begin
    out_q  <= take ? merged : dat_i;
    pend_q <= take;
  end

  a_r5_ack_after_take: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(cyc_i && stb_i && !rst));

  a_r5_ack_when_cyc_kept: assert property (@(posedge clk) disable iff (rst)
    ($past(cyc_i && stb_i && !rst) && cyc_i) |-> ack_o);

  a_r7_idle_echo: assert property (@(posedge clk) disable iff (rst)
    !$past(cyc_i && stb_i && !rst) |-> (dat_o == $past(dat_i)));

  a_r3_full_replace: assert property (@(posedge clk) disable iff (rst)
    $past(cyc_i && stb_i && !rst && we_i && (sel_i == 4'hF)) |-> (dat_o == $past(dat_i)));

  for (genvar g = 0; g < 4; g++) begin : g_lane_chk
    a_r2_lane_written: assert property (@(posedge clk) disable iff (rst)
      $past(cyc_i && stb_i && !rst && we_i && sel_i[g]) |-> (dat_o[8*g +: 8] == $past(dat_i[8*g +: 8])));
  end

endmodule

// File: tb/test_wb_word_ram.sv
module test_wb_word_ram;
  localparam int WORDS = 100;
  localparam int DEPTH = 128;
  localparam int AW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [31:0]   din = '0;
  logic [3:0]    sel = '0;
  logic          ack, stall;
  logic [31:0]   dout;

  typedef struct {
    logic        pend;
    logic [31:0] data;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] ref_mem [DEPTH];
  int          vectors = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  wb_word_ram #(.WORDS(WORDS), .AW(AW)) i_wb_word_ram (
    .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(din), .sel_i(sel),
    .ack_o(ack), .stall_o(stall), .dat_o(dout));

  task automatic drive(input logic r, input logic c, input logic s, input logic w,
                       input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [3:0] m, input string tag);
    item_t it;
    logic [31:0] msk, cur;
    @(negedge clk);
    rst = r; cyc = c; stb = s; we = w; adr = a; din = d; sel = m;
    @(posedge clk);
    it.tag = tag;
    if (!r && c && s) begin
      for (int g = 0; g < 4; g++) msk[8*g +: 8] = {8{m[g]}};
      cur = ref_mem[a % DEPTH];
      if (w) begin
        cur = (cur & ~msk) | (d & msk);
        ref_mem[a % DEPTH] = cur;
      end
      it.pend = 1'b1; it.data = cur;
    end else begin
      it.pend = 1'b0; it.data = d;
    end
    sb.push_back(it);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [3:0] m, input string tag);
    drive(0, 1, 1, 0, a, 32'hDEAD_0000 ^ 32'(a), m, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] m, input string tag);
    drive(0, 1, 1, 1, a, d, m, tag);
  endtask

  task automatic idle(input logic [31:0] d, input string tag);
    drive(0, 0, 0, 0, '0, d, 4'h0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() > 0) begin
        item_t it;
        logic exp_ack;
        it = sb.pop_front();
        exp_ack = it.pend && cyc;
        vectors++;
        if (stall !== 1'b0 || ack !== exp_ack || dout !== it.data) begin
          bad++;
          $display("FAIL %s: ack=%0b stall=%0b dat=%08h expected ack=%0b stall=0 dat=%08h",
                   it.tag, ack, stall, dout, exp_ack, it.data);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    // R8 reset state: no ack, idle echo
    drive(1, 0, 0, 0, '0, 32'h1111_2222, 4'h0, "R8");
    drive(1, 0, 0, 0, '0, 32'h3333_4444, 4'h0, "R8");
    // R9 unwritten words read zero
    rd(16'd3, 4'hF, "R9");
    rd(16'd99, 4'h0, "R9");
    // R3 full replace
    wr(16'd3, 32'hA1B2_C3D4, 4'hF, "R3");
    rd(16'd3, 4'hF, "R3");
    // R2 each lane alone, R6 write returns merged word
    wr(16'd3, 32'h0000_00EE, 4'h1, "R2");
    wr(16'd3, 32'h0000_5500, 4'h2, "R2");
    wr(16'd3, 32'h0077_0000, 4'h4, "R2");
    wr(16'd3, 32'h9900_0000, 4'h8, "R2");
    wr(16'd3, 32'hFFFF_FFFF, 4'h0, "R3");
    wr(16'd3, 32'h1234_5678, 4'h5, "R3");
    rd(16'd3, 4'h0, "R6");
    // R1 wrap: address DEPTH+5 aliases 5, top depth boundary
    wr(16'd5, 32'hCAFE_F00D, 4'hF, "R1");
    rd(16'(DEPTH + 5), 4'hF, "R1");
    wr(16'(2*DEPTH + 127), 32'h0BAD_BEEF, 4'hF, "R1");
    rd(16'd127, 4'hF, "R1");
    // R4 back-to-back mixed stream
    for (int k = 0; k < 24; k++) begin
      if (k % 3 == 2) rd(16'(k % 7), 4'h3, "R4");
      else wr(16'(k % 7), 32'h0101_0101 * 32'(k + 1), 4'(k % 16), "R4");
    end
    // R7 idle echo, stb low inside a cycle
    idle(32'h5A5A_A5A5, "R7");
    idle(32'h0F0F_0F0F, "R7");
    drive(0, 1, 0, 1, 16'd3, 32'h7777_7777, 4'hF, "R7");
    rd(16'd3, 4'hF, "R7");
    // R5 cycle dropped right after request
    wr(16'd10, 32'h4444_5555, 4'hF, "R5");
    idle(32'h0, "R5");
    rd(16'd10, 4'hF, "R5");
    drive(0, 0, 0, 0, '0, 32'h8888_9999, 4'h0, "R5");
    rd(16'd10, 4'hF, "R5");
    // R8 request during reset is ignored, memory kept
    drive(1, 1, 1, 1, 16'd10, 32'hFFFF_0000, 4'hF, "R8");
    rd(16'd10, 4'hF, "R8");
    rd(16'd3, 4'hF, "R8");
    idle(32'h1357_9BDF, "R8");
    idle(32'h0, "end");
    repeat (2) @(posedge clk);
    #4;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule